// File: doc/BRIEF.md
# Dice-Roll Modulo-Six Counter

This block is a synchronous 4-bit counter that produces the face value of an electronic die. A free-running clock steps it through 1, 2, 3, 4, 5, 6 and back to 1 while the roll enable is high. When the enable drops, the value freezes and stays on display.

The wrap is not a full compare. The block looks only at count bits 1 and 2. When both are high, the next edge loads the preset value 1 instead of incrementing. Because of this, any value the register may hold at power-up finds its own way back into the 1-to-6 loop. An active-high initialise input forces the same load and places the counter at 1.

A seven-segment encoder drives an active-high pattern for the current value.

Top module: `dice_counter`

## Requirements
- R1: While rst_ni is low, count_o takes the parameter RST_VAL, which models the register contents at power-up (default 1).
- R2: With en_i high and init_i low, starting from 1, count_o follows 1,2,3,4,5,6,1,... and changes only at rising clock edges.
- R3: When count bits 2 and 1 are both 1 and en_i is high, the next rising edge loads 4'b0001; 6 never advances to 7. Bits 0 and 3 are not examined.
- R4: When en_i is high, init_i is low and count bits 2:1 are not both 1, the next edge loads count_o plus one.
- R5: Values outside 1 to 6 recover with en_i high, as follows. 0 goes to 1. 7, 14 and 15 go to 1 on the next edge. 8 through 13 step up to 14 and then load 1.
- R6: When init_i is high at a rising edge, count_o becomes 1 at that edge, whatever en_i is.
- R7: When en_i and init_i are both low at a rising edge, count_o keeps its value.
- R8: seg_o is ordered {g,f,e,d,c,b,a} with 1 = lit. The patterns are: 1 = 0000110, 2 = 1011011, 3 = 1001111, 4 = 1100110, 5 = 1101101, 6 = 1111101.
- R9: seg_o is all zeros whenever count_o is outside 1 to 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset, loads RST_VAL |
| en_i | input | 1 | Roll enable; low freezes the count |
| init_i | input | 1 | Active-high initialise; forces a load of 1 |
| count_o | output | WIDTH | Current count value |
| seg_o | output | 7 | Active-high segments {g,f,e,d,c,b,a} |

## Verification
The assertions check the following on every clock edge:
- a decoded wrap or an init reloads the preset;
- an enabled count outside the wrap decode steps by exactly one;
- a count with neither enable nor init holds;
- every lit pattern carries at least two segments.

Other behaviour can be shown only by the bench's scenarios. These are the full recovery paths from all sixteen power-up values, the exact segment shapes, and the complete 1-to-6 cycle over many edges. For them the bench runs sixteen extra instances, each with a different RST_VAL, beside a main instance. The main instance is driven by directed sequences and seeded random enable and init patterns.

// File: rtl/dice_pkg.sv
package dice_pkg;
  localparam int unsigned SEG_W = 7;
  typedef logic [SEG_W-1:0] seg_t;

  // {g,f,e,d,c,b,a}, active high
  function automatic seg_t face_pattern(input int unsigned v);
    case (v)
      1:       return 7'b0000110;
      2:       return 7'b1011011;
      3:       return 7'b1001111;
      4:       return 7'b1100110;
      5:       return 7'b1101101;
      6:       return 7'b1111101;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/dice_wrap_decode.sv
module dice_wrap_decode #(
  parameter int unsigned WIDTH = 4,
  parameter logic [WIDTH-1:0] PRESET = 1
) (
  input  logic [WIDTH-1:0] cnt_i,
  input  logic             en_i,
  input  logic             init_i,
  output logic             upd_o,
  output logic             load_o,
  output logic [WIDTH-1:0] nxt_o
);
  localparam int unsigned DEC_LO = 1;
  localparam int unsigned DEC_HI = 2;

  logic wrap_hit;

  // partial decode: only bits 2:1 are examined
  assign wrap_hit = cnt_i[DEC_HI] & cnt_i[DEC_LO];
  assign load_o   = init_i | wrap_hit;
  assign upd_o    = en_i | init_i;
  assign nxt_o    = load_o ? PRESET : cnt_i + WIDTH'(1);

  initial begin
    assert (WIDTH > DEC_HI) else $error("WIDTH too small for wrap decode");
  end
endmodule

// File: rtl/dice_count_reg.sv
module dice_count_reg #(
  parameter int unsigned WIDTH = 4,
  parameter logic [WIDTH-1:0] RST_VAL = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             upd_i,
  input  logic [WIDTH-1:0] nxt_i,
  output logic [WIDTH-1:0] cnt_o
);
  logic [WIDTH-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= RST_VAL;
    else if (upd_i) cnt_q <= nxt_i;
  end

  assign cnt_o = cnt_q;

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(cnt_o));
endmodule

// File: rtl/dice_seg_enc.sv
module dice_seg_enc
  import dice_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] cnt_i,
  output seg_t             seg_o
);
  always_comb seg_o = face_pattern(int'(cnt_i));

  always_comb begin
    assert_seg_shape_R8: assert ((seg_o == '0) || ($countones(seg_o) >= 2));
  end
endmodule

// File: rtl/dice_counter.sv
module dice_counter
  import dice_pkg::*;
#(
  parameter int unsigned WIDTH = 4,
  parameter logic [WIDTH-1:0] RST_VAL = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             init_i,
  output logic [WIDTH-1:0] count_o,
  output logic [SEG_W-1:0] seg_o
);
  localparam logic [WIDTH-1:0] PRESET = WIDTH'(1);

  logic             upd, load;
  logic [WIDTH-1:0] nxt, cnt;

  dice_wrap_decode #(.WIDTH(WIDTH), .PRESET(PRESET)) u_dec (
    .cnt_i (cnt),
    .en_i  (en_i),
    .init_i(init_i),
    .upd_o (upd),
    .load_o(load),
    .nxt_o (nxt)
  );

  dice_count_reg #(.WIDTH(WIDTH), .RST_VAL(RST_VAL)) u_reg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .upd_i (upd),
    .nxt_i (nxt),
    .cnt_o (cnt)
  );

  dice_seg_enc #(.WIDTH(WIDTH)) u_seg (
    .cnt_i(cnt),
    .seg_o(seg_o)
  );

  assign count_o = cnt;

  assert_wrap_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && count_o[2] && count_o[1]) |=> (count_o == PRESET));

  assert_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !init_i && !(count_o[2] && count_o[1]))
      |=> (count_o == WIDTH'($past(count_o) + WIDTH'(1))));

  assert_init_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> (count_o == PRESET));

  assert_load_path_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd && load) |=> (count_o == PRESET));
endmodule

// File: tb/test_dice_counter.sv
module test_dice_counter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, init = 1'b0, rec_en = 1'b0;
  logic [3:0] count;
  logic [6:0] seg;
  logic [3:0] rec_cnt [16];
  logic [6:0] rec_seg [16];
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dice_counter i_dice_counter (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .init_i(init),
    .count_o(count), .seg_o(seg)
  );

  for (genvar g = 0; g < 16; g++) begin : g_rec
    dice_counter #(.RST_VAL(4'(g))) i_rec (
      .clk_i(clk), .rst_ni(rst_n), .en_i(rec_en), .init_i(1'b0),
      .count_o(rec_cnt[g]), .seg_o(rec_seg[g])
    );
  end

  function automatic logic [3:0] nxt(input logic [3:0] v, input logic e, input logic i);
    if (!e && !i) return v;
    if (i || (v[2] && v[1])) return 4'd1;
    return v + 4'd1;
  endfunction

  function automatic logic [6:0] seg_exp(input logic [3:0] v);
    case (v)
      4'd1: return 7'b0000110;
      4'd2: return 7'b1011011;
      4'd3: return 7'b1001111;
      4'd4: return 7'b1100110;
      4'd5: return 7'b1101101;
      4'd6: return 7'b1111101;
      default: return 7'b0;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  logic [3:0] exp_main;
  logic [3:0] exp_rec [16];

  task automatic step(input logic e, input logic i, input string req);
    en = e; init = i;
    @(negedge clk);
    exp_main = nxt(exp_main, e, i);
    chk(req, count, exp_main);
    chk((exp_main >= 1 && exp_main <= 6) ? "R8" : "R9", seg, seg_exp(exp_main));
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1: reset value of every instance
    chk("R1", count, 1);
    chk("R8", seg, seg_exp(4'd1));
    for (int k = 0; k < 16; k++) chk("R1", rec_cnt[k], k);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7", count, 1);
    for (int k = 0; k < 16; k++) begin
      exp_rec[k] = 4'(k);
      chk("R7", rec_cnt[k], k);
    end

    // R5: recovery from all sixteen start values, R9 on out-of-range faces
    rec_en = 1'b1;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      for (int k = 0; k < 16; k++) begin
        exp_rec[k] = nxt(exp_rec[k], 1'b1, 1'b0);
        chk("R5", rec_cnt[k], exp_rec[k]);
        chk((exp_rec[k] >= 1 && exp_rec[k] <= 6) ? "R8" : "R9",
            rec_seg[k], seg_exp(exp_rec[k]));
      end
    end
    rec_en = 1'b0;

    // R2/R3/R4: full cycle over 25 edges
    exp_main = 4'd1;
    for (int c = 0; c < 25; c++) step(1'b1, 1'b0, "R2");
    // run to 3, then init with enable low
    while (exp_main != 4'd3) step(1'b1, 1'b0, "R4");
    step(1'b0, 1'b1, "R6");
    chk("R6", count, 1);
    // hold for several edges
    step(1'b1, 1'b0, "R4");
    for (int c = 0; c < 4; c++) step(1'b0, 1'b0, "R7");
    // init with enable high at 6
    while (exp_main != 4'd6) step(1'b1, 1'b0, "R4");
    step(1'b1, 1'b1, "R6");
    while (exp_main != 4'd6) step(1'b1, 1'b0, "R4");
    step(1'b1, 1'b0, "R3");
    chk("R3", count, 1);

    // random phase
    for (int c = 0; c < 400; c++) begin
      logic e, i;
      e = ($urandom % 4) != 0;
      i = ($urandom % 10) == 0;
      step(e, i, i ? "R6" : (!e ? "R7" : (exp_main == 4'd6 ? "R3" : "R2")));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule